// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervisory timer for a system management hub. Software sets a start value, clears the halt bit, and then services the timer by writing the reload location. A free-running prescaler turns the system clock into a fixed tick; the counter drops by one per tick. When the counter is at zero and a tick arrives, the counter reloads from the start value and keeps running.

The first such expiry only raises a timeout flag. If software leaves that flag set until the next expiry, the block records a second-timeout flag and issues a one-cycle reboot request. A strap input can block the request while the flags still record what happened.

The register file sits on a simple synchronous bus with byte offsets and 16-bit data. Reads return data one clock after the read strobe. A build parameter picks one of two variants: a 10-bit start-value field, or a 6-bit one at a different offset.

Top module: `wdt_top`

## Requirements
- R1: After synchronous reset the halt bit (bit 11 at offset 0x08) is 1, the start value reads 4, the counter reads 4, all status flags read 0, `reboot_req` is low and `bus_rdata` is 0 while no read is pending.
- R2: A write to the start-value register (offset 0x12 with 10-bit field, or 0x01 with 6-bit field) stores the field in the low bits and the remaining upper bits as written, and a read returns all 16 bits as stored.
- R3: A start-value write whose field (low bits only) is below 4 is ignored in full, so the stored register keeps its previous contents.
- R4: Any write to offset 0x00 loads the counter with the start value and restarts the tick interval. A read of 0x00 returns the current count in the low bits.
- R5: While the halt bit is 1 the count holds. While it is 0 the count drops by one every TICK_CYCLES clocks, the first drop coming TICK_CYCLES clocks after the halt bit clears. Other control bits read 0.
- R6: A tick that finds the count at 0 is an expiry. The counter reloads from the start value, and if bit 3 at offset 0x04 is clear it is set.
- R7: An expiry while bit 3 at 0x04 is already set sets bit 1 at 0x06 (second timeout) and bit 2 at 0x06 (reboot issued), and drives `reboot_req` high for exactly one clock, in the cycle after the expiry edge.
- R8: If software clears bit 3 at 0x04 between expiries, the next expiry counts as a first expiry again, with no second timeout and no reboot request.
- R9: While `no_reboot` is high a second expiry still sets bit 1 at 0x06, but `reboot_req` stays low and bit 2 at 0x06 is not set.
- R10: Each status flag clears only when 1 is written to its own bit. Writing 0 leaves it set, and a hardware set in the same cycle wins over the clear.
- R11: Reads of offsets not mapped in the built variant, including the other variant's start-value offset, return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` the next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, zero when no read was requested |
| no_reboot | input | 1 | Strap that blocks the reboot request |
| reboot_req | output | 1 | One-cycle registered reboot request |

## Verification
The hardest state to reach from the ports is a second expiry with the first flag still set. Reaching it takes two full countdowns with no service between them. The stimulus sets the smallest legal start value, reloads while halted, and clears the halt bit on a known cycle, so every later drop and both expiries fall on cycle numbers the bench can compute. The same timeline is then run three ways: unserviced, serviced between expiries, and with the strap high. Each run shows whether the second-timeout flag, the reboot flag and the pulse are set apart correctly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register offsets, byte addressed
  localparam logic [4:0] OFS_RELOAD      = 5'h00;
  localparam logic [4:0] OFS_INIT_NARROW = 5'h01;
  localparam logic [4:0] OFS_STS1        = 5'h04;
  localparam logic [4:0] OFS_STS2        = 5'h06;
  localparam logic [4:0] OFS_CTRL        = 5'h08;
  localparam logic [4:0] OFS_INIT_WIDE   = 5'h12;

  // Bit positions software relies on
  localparam int HALT_BIT = 11;
  localparam int TO1_BIT  = 3;
  localparam int TO2_BIT  = 1;
  localparam int BOOT_BIT = 2;

  // Smallest legal start value, also the reset value
  localparam int INIT_FLOOR = 4;

  typedef struct packed {
    logic to1;
    logic to2;
    logic boot;
  } wdt_flags_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PS_W = $clog2(TICK_CYCLES > 1 ? TICK_CYCLES : 2);
  localparam logic [PS_W-1:0] LAST = PS_W'(TICK_CYCLES - 1);

  logic [PS_W-1:0] ps_q;

  assign tick = !clr && (ps_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ps_q <= '0;
    end else if (ps_q == LAST) begin
      ps_q <= '0;
    end else begin
      ps_q <= ps_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = tick && !load && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(INIT_FLOOR);
    end else if (load || expire) begin
      cnt_q <= init_val;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter bit WIDE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              no_reboot,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output logic [CNT_W-1:0]  init_val,
  output logic              halt,
  output logic              load,
  output wdt_flags_t        flags,
  output logic              reboot_req,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int SPARE_W = DATA_W - CNT_W;
  localparam logic [4:0] INIT_OFS5 = WIDE ? OFS_INIT_WIDE : OFS_INIT_NARROW;
  localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(INIT_OFS5);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
  localparam logic [ADDR_W-1:0] A_STS1   = ADDR_W'(OFS_STS1);
  localparam logic [ADDR_W-1:0] A_STS2   = ADDR_W'(OFS_STS2);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [CNT_W-1:0]  FLOOR_V  = CNT_W'(INIT_FLOOR);

  logic [CNT_W-1:0]   init_q;
  logic [SPARE_W-1:0] spare_q;
  logic               halt_q;
  wdt_flags_t         flg_q;
  logic               reboot_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_val;

  logic wr_init, wr_sts1, wr_sts2, wr_ctrl;
  logic first_exp, second_exp;

  assign wr_init = bus_wr && (bus_addr == A_INIT) && (bus_wdata[CNT_W-1:0] >= FLOOR_V);
  assign wr_sts1 = bus_wr && (bus_addr == A_STS1);
  assign wr_sts2 = bus_wr && (bus_addr == A_STS2);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign load    = bus_wr && (bus_addr == A_RELOAD);

  assign first_exp  = expire && !flg_q.to1;
  assign second_exp = expire &&  flg_q.to1;

  // Start value and control
  always_ff @(posedge clk) begin
    if (rst) begin
      init_q  <= FLOOR_V;
      spare_q <= '0;
      halt_q  <= 1'b1;
    end else begin
      if (wr_init) begin
        init_q  <= bus_wdata[CNT_W-1:0];
        spare_q <= bus_wdata[DATA_W-1:CNT_W];
      end
      if (wr_ctrl) begin
        halt_q <= bus_wdata[HALT_BIT];
      end
    end
  end

  // Status flags: hardware set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q    <= '0;
      reboot_q <= 1'b0;
    end else begin
      if (first_exp) begin
        flg_q.to1 <= 1'b1;
      end else if (wr_sts1 && bus_wdata[TO1_BIT]) begin
        flg_q.to1 <= 1'b0;
      end
      if (second_exp) begin
        flg_q.to2 <= 1'b1;
      end else if (wr_sts2 && bus_wdata[TO2_BIT]) begin
        flg_q.to2 <= 1'b0;
      end
      if (second_exp && !no_reboot) begin
        flg_q.boot <= 1'b1;
      end else if (wr_sts2 && bus_wdata[BOOT_BIT]) begin
        flg_q.boot <= 1'b0;
      end
      reboot_q <= second_exp && !no_reboot;
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_RELOAD: rd_val[CNT_W-1:0] = cnt;
      A_INIT:   rd_val = {spare_q, init_q};
      A_STS1:   rd_val[TO1_BIT] = flg_q.to1;
      A_STS2: begin
        rd_val[TO2_BIT]  = flg_q.to2;
        rd_val[BOOT_BIT] = flg_q.boot;
      end
      A_CTRL:   rd_val[HALT_BIT] = halt_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= bus_rd ? rd_val : '0;
    end
  end

  assign init_val   = init_q;
  assign halt       = halt_q;
  assign flags      = flg_q;
  assign reboot_req = reboot_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICK_CYCLES = 60000000,
  parameter bit WIDE        = 1'b1,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              no_reboot,
  output logic              reboot_req
);
  localparam int CNT_W = WIDE ? 10 : 6;

  logic             tick;
  logic             load;
  logic             halt;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] init_val;
  wdt_flags_t       flg;

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_ps (
    .clk  (clk),
    .rst  (rst),
    .clr  (halt || load),
    .tick (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .init_val (init_val),
    .cnt      (cnt),
    .expire   (expire)
  );

  wdt_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .WIDE   (WIDE)
  ) u_rf (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .no_reboot  (no_reboot),
    .cnt        (cnt),
    .expire     (expire),
    .init_val   (init_val),
    .halt       (halt),
    .load       (load),
    .flags      (flg),
    .reboot_req (reboot_req),
    .bus_rdata  (bus_rdata)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             no_reboot,
  input logic             reboot_req,
  input logic             halt,
  input logic             load,
  input logic             tick,
  input logic             expire,
  input logic             to2,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_val
);
  assert_init_floor_R3: assert property (@(posedge clk) disable iff (rst)
    init_val >= CNT_W'(4));

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(init_val)));

  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (halt && !load) |=> $stable(cnt));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_expire_reload_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == $past(init_val)));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    reboot_req |=> !reboot_req);

  assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (rst)
    reboot_req |-> to2);

  assert_strap_block_R9: assert property (@(posedge clk) disable iff (rst)
    reboot_req |-> !$past(no_reboot));
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .no_reboot  (no_reboot),
  .reboot_req (reboot_req),
  .halt       (halt),
  .load       (load),
  .tick       (tick),
  .expire     (expire),
  .to2        (flg.to2),
  .cnt        (cnt),
  .init_val   (init_val)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 8;
  localparam int NVEC       = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        no_reboot = 1'b0;
  wire  [15:0] bus_rdata;
  wire         reboot_req;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int pulses = 0, hi_run = 0, max_run = 0;
  bit done = 1'b0;

  // {addr, write data, expected read-back}
  localparam logic [36:0] VEC [NVEC] = '{
    {5'h12, 16'h0005, 16'h0005},
    {5'h12, 16'hFC0A, 16'hFC0A},
    {5'h12, 16'h0003, 16'hFC0A},
    {5'h12, 16'h0000, 16'hFC0A},
    {5'h12, 16'h0004, 16'h0004},
    {5'h12, 16'h03FF, 16'h03FF},
    {5'h12, 16'h0402, 16'h03FF},
    {5'h08, 16'h0800, 16'h0800},
    {5'h08, 16'hFFFF, 16'h0800},
    {5'h01, 16'h0055, 16'h0000},
    {5'h02, 16'hFFFF, 16'h0000},
    {5'h04, 16'h0008, 16'h0000},
    {5'h00, 16'h1234, 16'h03FF},
    {5'h12, 16'h0004, 16'h0004}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 4, 5, 13: return "R2";
      2, 3, 6:        return "R3";
      7, 8:           return "R5";
      9, 10:          return "R11";
      11:             return "R10";
      default:        return "R4";
    endcase
  endfunction

  wdt_top #(.TICK_CYCLES(TICK), .WIDE(1'b1)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .no_reboot  (no_reboot),
    .reboot_req (reboot_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reboot_req) begin
      pulses <= pulses + 1;
      hi_run <= hi_run + 1;
      if (hi_run + 1 > max_run) max_run <= hi_run + 1;
    end else begin
      hi_run <= 0;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int u;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata idle", bus_rdata, 16'h0000);
    chk("R1 reboot low", {15'd0, reboot_req}, 16'h0000);
    rd(5'h08, d); chk("R1 halt", d, 16'h0800);
    rd(5'h12, d); chk("R1 start value", d, 16'h0004);
    rd(5'h04, d); chk("R1 sts1", d, 16'h0000);
    rd(5'h06, d); chk("R1 sts2", d, 16'h0000);
    rd(5'h00, d); chk("R1 count", d, 16'h0004);

    // Register vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][36:32], VEC[i][31:16]);
      rd(VEC[i][36:32], d);
      chk(vec_tag(i), d, VEC[i][15:0]);
    end

    // Unserviced run: two expiries (R5 R6 R7 R10)
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000); u = cyc;
    wait_to(u + 4);  rd(5'h00, d); chk("R5 count 4", d, 16'h0004);
    wait_to(u + 12); rd(5'h00, d); chk("R5 count 3", d, 16'h0003);
    wait_to(u + 36); rd(5'h00, d); chk("R6 count 0", d, 16'h0000);
    rd(5'h04, d); chk("R6 no flag yet", d, 16'h0000);
    wait_to(u + 44); rd(5'h04, d); chk("R6 first flag", d, 16'h0008);
    rd(5'h00, d); chk("R6 reloaded", d, 16'h0004);
    chk("R6 no pulse", 16'(pulses), 16'd0);
    wait_to(u + 84); rd(5'h06, d); chk("R7 second flags", d, 16'h0006);
    chk("R7 one pulse", 16'(pulses), 16'd1);
    chk("R7 width", 16'(max_run), 16'd1);
    wr(5'h08, 16'h0800);
    wr(5'h06, 16'h0000); rd(5'h06, d); chk("R10 zero write sts2", d, 16'h0006);
    wr(5'h04, 16'h0000); rd(5'h04, d); chk("R10 zero write sts1", d, 16'h0008);
    wr(5'h06, 16'h0002); rd(5'h06, d); chk("R10 clear to2 only", d, 16'h0004);
    wr(5'h06, 16'h0004); rd(5'h06, d); chk("R10 clear boot", d, 16'h0000);
    wr(5'h04, 16'h0008); rd(5'h04, d); chk("R10 clear sts1", d, 16'h0000);

    // Serviced run (R8)
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000); u = cyc;
    wait_to(u + 50); wr(5'h04, 16'h0008);
    wait_to(u + 84); rd(5'h06, d); chk("R8 no second", d, 16'h0000);
    rd(5'h04, d); chk("R8 first again", d, 16'h0008);
    chk("R8 no new pulse", 16'(pulses), 16'd1);
    wr(5'h08, 16'h0800);
    wr(5'h04, 16'h0008);

    // Strap high (R9)
    no_reboot = 1'b1;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000); u = cyc;
    wait_to(u + 84); rd(5'h06, d); chk("R9 to2 only", d, 16'h0002);
    chk("R9 pulse blocked", 16'(pulses), 16'd1);
    wr(5'h08, 16'h0800);
    no_reboot = 1'b0;
    wr(5'h04, 16'h0008);
    wr(5'h06, 16'h0006);

    // Halt mid-count (R5)
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000); u = cyc;
    wait_to(u + 20); wr(5'h08, 16'h0800);
    wait_to(u + 70); rd(5'h00, d); chk("R5 held at 2", d, 16'h0002);

    // Reload mid-count restarts the interval (R4)
    wr(5'h08, 16'h0000); u = cyc;
    wait_to(u + 4);  wr(5'h00, 16'hABCD);
    rd(5'h00, d); chk("R4 reload", d, 16'h0004);
    wait_to(u + 16); rd(5'h00, d); chk("R4 restarted interval", d, 16'h0003);
    wr(5'h08, 16'h0800);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule